// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds the pending state of 22 interrupt sources as latches packed into three consecutive byte-wide registers on a CPU data bus. A one-cycle request pulse from a peripheral sets that source's latch. When the CPU accepts a source, it sends an acknowledge strobe with the source number, and the block clears that one latch. The full pending vector goes continuously to a downstream masking and priority stage.

Software reads the registers and writes them in three ways. A bit operation sets or clears one latch. A byte write replaces one register. A word write at the base address replaces the two lower registers together. A bit operation touches only its own latch. A byte or word write replaces every latch it covers, so a read-modify-write sequence in software can erase a request that arrives between its read and its write. The block keeps that behaviour and adds no guard against it.

Top module: `irq_flag_bank`

## Requirements
- R1: While `rst_n` is low, every latch is 0, and every read returns 0000h.
- R2: A 1 on `req_pulse[i]` at a clock edge sets latch i at that edge. A pulse on a latch that is already set leaves the vector unchanged.
- R3: `ack_stb` with `ack_idx` below 22 clears only latch `ack_idx` at the edge. An index of 22 or more changes nothing.
- R4: A bit operation (`bus_we`=1, `bus_bitop`=1) at byte address A in FFE0h..FFE2h writes `bus_bitset` into bit `bus_bitidx` of the register at A. Every other latch is left alone.
- R5: A byte write (`bus_we`=1, `bus_bitop`=0, `bus_word`=0) at FFE0h, FFE1h or FFE2h replaces that register with `bus_wdata[7:0]`. A byte write to any other address is ignored.
- R6: A word write (`bus_word`=1) at FFE0h puts `bus_wdata[7:0]` into FFE0h and `bus_wdata[15:8]` into FFE1h. A word write at any other address is ignored.
- R7: Bits 7 and 6 of FFE2h always read 0, and writing 1 to them has no effect.
- R8: A request pulse on a latch wins over a software write of 0 and over an acknowledge aimed at the same latch in the same cycle.
- R9: A request on one latch during a bit-clear of another latch in the same register leaves the requested latch set.
- R10: A byte write of a stale register image clears any latch that was set after the image was read.
- R11: Reads are combinational. A byte read of a mapped register returns it in `bus_rdata[7:0]` with the upper byte 0. A word read at FFE0h returns {FFE1h, FFE0h}. Every other read returns 0000h.
- R12: Latch i sits at bit i mod 8 of the register at FFE0h + i/8 and drives `flags_o[i]`.
- R13: A software write to a latch takes precedence over an acknowledge of the same latch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | 22 | One-cycle request pulses, one per source |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_idx | input | 5 | Source number being acknowledged |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Byte address |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_bitop | input | 1 | 1 = single-bit write |
| bus_bitidx | input | 3 | Bit position for a single-bit write |
| bus_bitset | input | 1 | Value written by a single-bit write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| flags_o | output | 22 | Pending vector to the priority stage |

## Verification
The stimulus uses three kinds of access: isolated request and acknowledge events, each single-bit, byte and word write on its own, and cycles in which a request, an acknowledge and a software write hit the same latch or the same register together. The isolated cases show where each latch sits in the map and check that out-of-range addresses and indices do nothing. The collision cases separate the three precedence rules from one another. A scripted read-then-write sequence shows that a request can be lost. A long run of random mixed traffic is then compared every cycle against a behavioural model of the whole vector and the read data.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_BIT,
        ACC_BYTE,
        ACC_WORD
    } acc_kind_e;
endpackage

// File: rtl/irqf_bus_decode.sv
module irqf_bus_decode
    import irqf_pkg::*;
#(
    parameter int                NUM_FLAGS = 22,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFE0,
    localparam int               NUM_REGS  = (NUM_FLAGS + 7) / 8
) (
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_word,
    input  logic                 bus_bitop,
    input  logic [2:0]           bus_bitidx,
    input  logic                 bus_bitset,
    input  logic [15:0]          bus_wdata,
    output logic [NUM_REGS-1:0]  reg_hit,
    output logic                 word_hit,
    output logic [NUM_FLAGS-1:0] sw_en,
    output logic [NUM_FLAGS-1:0] sw_val
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    acc_kind_e         kind;

    assign offset   = bus_addr - BASE_ADDR;
    assign in_range = (bus_addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_REGS));
    assign word_hit = (bus_addr == BASE_ADDR);

    always_comb begin
        if (!bus_we)        kind = ACC_IDLE;
        else if (bus_bitop) kind = ACC_BIT;
        else if (bus_word)  kind = ACC_WORD;
        else                kind = ACC_BYTE;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
        assign reg_hit[r] = in_range && (offset == ADDR_W'(r));
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int REG = i / 8;
        localparam int BIT = i % 8;
        logic word_en;
        logic word_val;

        if (REG < 2) begin : g_word
            assign word_en  = word_hit;
            assign word_val = bus_wdata[REG*8 + BIT];
        end else begin : g_noword
            assign word_en  = 1'b0;
            assign word_val = 1'b0;
        end

        always_comb begin
            sw_en[i]  = 1'b0;
            sw_val[i] = 1'b0;
            unique case (kind)
                ACC_IDLE: begin
                    sw_en[i]  = 1'b0;
                end
                ACC_BIT: begin
                    sw_en[i]  = reg_hit[REG] && (bus_bitidx == 3'(BIT));
                    sw_val[i] = bus_bitset;
                end
                ACC_BYTE: begin
                    sw_en[i]  = reg_hit[REG];
                    sw_val[i] = bus_wdata[BIT];
                end
                ACC_WORD: begin
                    sw_en[i]  = word_en;
                    sw_val[i] = word_val;
                end
                default: begin
                    sw_en[i]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/irqf_ack_decode.sv
module irqf_ack_decode #(
    parameter int NUM_FLAGS = 22,
    parameter int IDX_W     = 5
) (
    input  logic                 ack_stb,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_FLAGS-1:0] ack_clr
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        assign ack_clr[i] = ack_stb && (ack_idx == IDX_W'(i));
    end
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_en,
    input  logic sw_val,
    input  logic ack_clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= 1'b0;
        else if (hw_set)  q <= 1'b1;
        else if (sw_en)   q <= sw_val;
        else if (ack_clr) q <= 1'b0;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int          NUM_FLAGS = 22,
    parameter int          IDX_W     = $clog2(NUM_FLAGS),
    parameter logic [15:0] BASE_ADDR = 16'hFFE0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] req_pulse,
    input  logic                 ack_stb,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_word,
    input  logic                 bus_bitop,
    input  logic [2:0]           bus_bitidx,
    input  logic                 bus_bitset,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    output logic [NUM_FLAGS-1:0] flags_o
);
    localparam int NUM_REGS = (NUM_FLAGS + 7) / 8;
    localparam int IMG_W    = NUM_REGS * 8;

    logic [NUM_REGS-1:0]  reg_hit;
    logic                 word_hit;
    logic [NUM_FLAGS-1:0] sw_en;
    logic [NUM_FLAGS-1:0] sw_val;
    logic [NUM_FLAGS-1:0] ack_clr;
    logic [IMG_W-1:0]     img;

    irqf_bus_decode #(
        .NUM_FLAGS (NUM_FLAGS),
        .ADDR_W    (16),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus_dec (
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_word   (bus_word),
        .bus_bitop  (bus_bitop),
        .bus_bitidx (bus_bitidx),
        .bus_bitset (bus_bitset),
        .bus_wdata  (bus_wdata),
        .reg_hit    (reg_hit),
        .word_hit   (word_hit),
        .sw_en      (sw_en),
        .sw_val     (sw_val)
    );

    irqf_ack_decode #(
        .NUM_FLAGS (NUM_FLAGS),
        .IDX_W     (IDX_W)
    ) u_ack_dec (
        .ack_stb (ack_stb),
        .ack_idx (ack_idx),
        .ack_clr (ack_clr)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
        irqf_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (req_pulse[i]),
            .sw_en   (sw_en[i]),
            .sw_val  (sw_val[i]),
            .ack_clr (ack_clr[i]),
            .q       (flags_o[i])
        );
    end

    if (IMG_W > NUM_FLAGS) begin : g_pad
        assign img = {{(IMG_W - NUM_FLAGS){1'b0}}, flags_o};
    end else begin : g_nopad
        assign img = flags_o;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_word) begin
            if (word_hit) bus_rdata = img[15:0];
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (reg_hit[r]) bus_rdata[7:0] = img[r*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int          NUM_FLAGS = 22,
    parameter int          IDX_W     = 5,
    parameter logic [15:0] BASE_ADDR = 16'hFFE0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] req_pulse,
    input logic                 ack_stb,
    input logic [IDX_W-1:0]     ack_idx,
    input logic                 bus_we,
    input logic [15:0]          bus_addr,
    input logic                 bus_word,
    input logic                 bus_bitop,
    input logic [15:0]          bus_rdata,
    input logic [NUM_FLAGS-1:0] flags_o
);
    localparam logic [15:0] TOP_ADDR = BASE_ADDR + 16'd2;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0));

    assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(req_pulse)) == $past(req_pulse)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !bus_we && (int'(ack_idx) < NUM_FLAGS) && (req_pulse == '0))
        |=> ((flags_o & (NUM_FLAGS'(1) << $past(ack_idx))) == '0));

    assert_bitop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_bitop && !ack_stb && (req_pulse == '0))
        |=> ($countones(flags_o ^ $past(flags_o)) <= 1));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((flags_o & ~$past(flags_o) & ~$past(req_pulse)) == '0));

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == TOP_ADDR) && !bus_word) |-> (bus_rdata[15:6] == '0));

    assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr < BASE_ADDR) || (bus_addr > TOP_ADDR)) |-> (bus_rdata == '0));
endmodule

bind irq_flag_bank irqf_checker #(
    .NUM_FLAGS (NUM_FLAGS),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pulse (req_pulse),
    .ack_stb   (ack_stb),
    .ack_idx   (ack_idx),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_word  (bus_word),
    .bus_bitop (bus_bitop),
    .bus_rdata (bus_rdata),
    .flags_o   (flags_o)
);

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] req_pulse;
    logic        ack_stb;
    logic [4:0]  ack_idx;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic        bus_word;
    logic        bus_bitop;
    logic [2:0]  bus_bitidx;
    logic        bus_bitset;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [21:0] flags_o;

    int checks = 0;
    int failures = 0;
    logic [23:0] m = '0;
    logic [7:0]  got;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .ack_stb(ack_stb),
        .ack_idx(ack_idx), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_bitop(bus_bitop), .bus_bitidx(bus_bitidx),
        .bus_bitset(bus_bitset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flags_o(flags_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mnext(logic [23:0] cur);
        logic [23:0] n;
        int off;
        n = cur;
        if (ack_stb && ack_idx < 5'd22) n[ack_idx] = 1'b0;
        if (bus_we) begin
            off = int'(bus_addr) - 'hFFE0;
            if (bus_bitop) begin
                if (off >= 0 && off < 3) n[off*8 + int'(bus_bitidx)] = bus_bitset;
            end else if (bus_word) begin
                if (off == 0) n[15:0] = bus_wdata;
            end else if (off >= 0 && off < 3) begin
                for (int k = 0; k < 8; k++) n[off*8 + k] = bus_wdata[k];
            end
        end
        n[21:0] = n[21:0] | req_pulse;
        n[23:22] = 2'b00;
        return n;
    endfunction

    function automatic logic [15:0] mread();
        int off;
        off = int'(bus_addr) - 'hFFE0;
        if (bus_word) return (off == 0) ? m[15:0] : 16'h0000;
        if (off >= 0 && off < 3) return {8'h00, m[off*8 +: 8]};
        return 16'h0000;
    endfunction

    task automatic idle();
        req_pulse = '0; ack_stb = 0; ack_idx = '0; bus_we = 0;
        bus_addr = 16'h0000; bus_word = 0; bus_bitop = 0; bus_bitidx = '0;
        bus_bitset = 0; bus_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        m = mnext(m);
        @(negedge clk);
        chk("R12 model flags", 32'(flags_o), 32'(m[21:0]));
        chk("R11 model rdata", 32'(bus_rdata), 32'(mread()));
        idle();
    endtask

    task automatic rd(logic [15:0] a, logic w, logic [15:0] exp, string tag);
        idle();
        bus_addr = a; bus_word = w;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic wr(logic [15:0] a, logic w, logic [15:0] d);
        bus_we = 1; bus_addr = a; bus_word = w; bus_wdata = d;
    endtask

    task automatic bop(logic [15:0] a, logic [2:0] idx, logic v);
        bus_we = 1; bus_bitop = 1; bus_addr = a; bus_bitidx = idx; bus_bitset = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1 reset flags", 32'(flags_o), 0);
        rd(16'hFFE0, 1, 16'h0000, "R1 reset read");
        rst_n = 1;

        idle(); req_pulse = 22'h020201; tick();
        chk("R2 set", 32'(flags_o), 32'h020201);
        rd(16'hFFE2, 0, 16'h0002, "R12 map FFE2");
        rd(16'hFFE0, 1, 16'h0201, "R11 word read");

        idle(); req_pulse[0] = 1; tick();
        chk("R2 already set", 32'(flags_o), 32'h020201);

        idle(); ack_stb = 1; ack_idx = 5'd9; tick();
        chk("R3 ack clear", 32'(flags_o), 32'h020001);
        idle(); ack_stb = 1; ack_idx = 5'd25; tick();
        chk("R3 ack out of range", 32'(flags_o), 32'h020001);

        idle(); bop(16'hFFE1, 3'd4, 1); tick();
        chk("R4 bit set", 32'(flags_o), 32'h021001);

        idle(); bop(16'hFFE0, 3'd0, 0); req_pulse[5] = 1; tick();
        chk("R9 bit clear keeps neighbour", 32'(flags_o), 32'h021020);

        idle(); wr(16'hFFE2, 0, 16'h00FF); tick();
        chk("R7 FFE2 write", 32'(flags_o), 32'h3F1020);
        rd(16'hFFE2, 0, 16'h003F, "R7 unused bits read 0");

        idle(); wr(16'hFFE1, 0, 16'h00A5); tick();
        chk("R5 byte write", 32'(flags_o), 32'h3FA520);
        idle(); wr(16'hFFE3, 0, 16'h0077); tick();
        chk("R5 unmapped write ignored", 32'(flags_o), 32'h3FA520);

        idle(); wr(16'hFFE0, 1, 16'h1234); tick();
        chk("R6 word write", 32'(flags_o), 32'h3F1234);
        idle(); wr(16'hFFE1, 1, 16'hFFFF); tick();
        chk("R6 misplaced word ignored", 32'(flags_o), 32'h3F1234);

        idle(); wr(16'hFFE0, 0, 16'h0000); req_pulse[2] = 1; tick();
        chk("R8 request beats write", 32'(flags_o), 32'h3F1204);
        idle(); ack_stb = 1; ack_idx = 5'd2; req_pulse[2] = 1; tick();
        chk("R8 request beats ack", 32'(flags_o), 32'h3F1204);

        idle(); wr(16'hFFE0, 0, 16'h00FF); ack_stb = 1; ack_idx = 5'd1; tick();
        chk("R13 write beats ack", 32'(flags_o), 32'h3F12FF);

        idle(); wr(16'hFFE0, 0, 16'h0001); tick();
        rd(16'hFFE0, 0, 16'h0001, "R10 image read");
        got = bus_rdata[7:0];
        idle(); req_pulse[3] = 1; tick();
        chk("R10 arrival", 32'(flags_o), 32'h3F1209);
        idle(); wr(16'hFFE0, 0, {8'h00, got & 8'hFE}); tick();
        chk("R10 request lost", 32'(flags_o), 32'h3F1200);

        rd(16'hFFD0, 0, 16'h0000, "R11 unmapped read");
        rd(16'hFFE2, 1, 16'h0000, "R11 misplaced word read");

        for (int n = 0; n < 500; n++) begin
            idle();
            req_pulse = ($urandom % 4 == 0) ? 22'(1 << ($urandom % 22)) : '0;
            ack_stb = ($urandom % 3 == 0);
            ack_idx = 5'($urandom % 24);
            bus_we = ($urandom % 2 == 0);
            bus_addr = 16'hFFDF + 16'($urandom % 5);
            bus_word = ($urandom % 4 == 0);
            bus_bitop = ($urandom % 2 == 0);
            bus_bitidx = 3'($urandom);
            bus_bitset = 1'($urandom);
            bus_wdata = 16'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule